// File: doc/BRIEF.md
# SIMD Branch Divergence Stack

This block is the per-thread control unit that decides which lanes of a SIMD thread take part in each instruction while the thread runs nested IF-THEN-ELSE code. The issue stage hands it at most one decoded control event per cycle. The event is one of four kinds: a conditional branch, an ELSE marker, an ENDIF marker, or an unwind. A branch carries a per-lane predicate, a target address and a token. Markers carry a token and a target address. An unwind carries a stack level. The block answers with the active-lane mask and with a one-cycle redirect request that carries the address to fetch next. When no redirect is raised, fetch falls through.

When lanes disagree on a branch, the block saves the mask that was active before the IF on a bounded LIFO stack. Each stack entry holds a token, a target address and a mask. The block then narrows the active mask to the lanes that take the THEN path. When every active lane agrees, nothing is saved and fetch skips the THEN or ELSE region that no lane needs. Every lane either executes the single shared instruction or idles, as the mask shows.

Top module: `simd_div_stack`

## Requirements
- R1: After a synchronous reset, the active mask is all ones, the stack depth is 0, redirect is low and both error flags are low.
- R2: A branch (kind code 0) whose effective predicate (predicate AND active mask) is neither zero nor equal to the active mask pushes the entry {event token, event target, current mask}, raises the depth by one and sets the mask to the effective predicate, with no redirect.
- R3: A branch whose effective predicate is zero pushes nothing, leaves the mask unchanged and redirects to the event target.
- R4: A branch whose effective predicate equals the active mask pushes nothing, leaves the mask unchanged and raises no redirect.
- R5: Predicate bits of inactive lanes have no effect on the divergence decision or on the new mask.
- R6: An ELSE marker (kind code 1) whose token equals the top entry's token sets the mask to the saved mask AND NOT the current mask, keeps the depth and raises no redirect.
- R7: An ELSE marker whose token does not match the top entry, or that arrives with an empty stack, leaves mask and depth unchanged and redirects to the event target.
- R8: An ENDIF marker (kind code 2) whose token matches the top entry pops it and restores its saved mask. Any other ENDIF changes nothing and raises no redirect.
- R9: Entries nest in LIFO order. Only the most recently pushed entry can be matched by a marker.
- R10: An unwind (kind code 3) to level L, where L is below the depth, sets the depth to L, sets the mask to entry L's saved mask and redirects to entry L's target.
- R11: A divergent branch while the stack holds DEPTH entries pushes nothing, leaves mask and depth unchanged and sets a sticky overflow flag. That flag is cleared only by reset.
- R12: An unwind whose level is not below the depth changes nothing and sets a sticky underflow flag. That flag is cleared only by reset.
- R13: All outputs are registered and reflect an event on the cycle after it. Redirect is a one-cycle pulse. A cycle with no valid event changes neither mask nor depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | A control event is presented this cycle |
| ev_kind | input | 2 | 0 branch, 1 ELSE marker, 2 ENDIF marker, 3 unwind |
| ev_pred | input | LANES | Per-lane branch predicate, 1 = lane enters THEN |
| ev_target | input | AW | Branch skip target or marker redirect target |
| ev_token | input | TW | Identifier of the IF construct |
| ev_level | input | DW | Stack level for an unwind |
| active_mask | output | LANES | Lanes executing the current instruction |
| redirect | output | 1 | One-cycle request to fetch from redirect_pc |
| redirect_pc | output | AW | Redirect address |
| stack_depth | output | DW | Number of occupied stack entries |
| overflow_err | output | 1 | Sticky push-on-full error |
| underflow_err | output | 1 | Sticky bad-unwind error |

## Verification
The hardest state to reach from the ports is a full stack whose saved masks are all different, followed by a push attempt, an unwind into the middle of the stack and an out-of-range unwind. The bench reaches it by issuing a chain of divergent branches whose predicates shrink the mask one lane at a time. Each entry then holds a distinct mask that the later checks can tell apart. The other parts of the run are exhaustive. Every predicate value is swept both from the full mask and from a partial mask. In the partial-mask sweep, inactive lanes carry arbitrary predicate bits, which covers the rule that idle lanes never cause divergence.

// File: rtl/simd_div_pkg.sv
package simd_div_pkg;
  typedef enum logic [1:0] {
    EV_BRANCH = 2'd0,
    EV_ELSE   = 2'd1,
    EV_ENDIF  = 2'd2,
    EV_UNWIND = 2'd3
  } ev_kind_e;
endpackage

// File: rtl/simd_div_store.sv
// Stack storage: one write port, two asynchronous read ports (LUT RAM style).
module simd_div_store #(
  parameter int W     = 64,
  parameter int DEPTH = 8,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [IW-1:0] raddr_a,
  output logic [W-1:0]  rdata_a,
  input  logic [IW-1:0] raddr_b,
  output logic [W-1:0]  rdata_b
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/simd_div_cls.sv
// Classifies a branch predicate against the active mask.
module simd_div_cls #(
  parameter int LANES = 32
) (
  input  logic [LANES-1:0] mask,
  input  logic [LANES-1:0] pred,
  output logic [LANES-1:0] eff,
  output logic             none_take,
  output logic             all_take
);
  always_comb begin
    eff       = pred & mask;
    none_take = (eff == '0);
    all_take  = (eff == mask);
  end
endmodule

// File: rtl/simd_div_stack.sv
module simd_div_stack #(
  parameter int LANES = 32,
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int TW    = 4,
  localparam int DW   = $clog2(DEPTH + 1),
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ev_valid,
  input  logic [1:0]       ev_kind,
  input  logic [LANES-1:0] ev_pred,
  input  logic [AW-1:0]    ev_target,
  input  logic [TW-1:0]    ev_token,
  input  logic [DW-1:0]    ev_level,
  output logic [LANES-1:0] active_mask,
  output logic             redirect,
  output logic [AW-1:0]    redirect_pc,
  output logic [DW-1:0]    stack_depth,
  output logic             overflow_err,
  output logic             underflow_err
);
  import simd_div_pkg::*;

  localparam int EW = TW + AW + LANES;

  // stack storage
  logic          wr_en;
  logic [IW-1:0] wr_idx, top_idx, lvl_idx;
  logic [EW-1:0] wr_ent, top_ent, lvl_ent;

  assign top_idx = IW'(stack_depth - DW'(1));
  assign lvl_idx = IW'(ev_level);

  simd_div_store #(.W(EW), .DEPTH(DEPTH)) u_store (
    .clk    (clk),
    .we     (wr_en),
    .waddr  (wr_idx),
    .wdata  (wr_ent),
    .raddr_a(top_idx),
    .rdata_a(top_ent),
    .raddr_b(lvl_idx),
    .rdata_b(lvl_ent)
  );

  logic [TW-1:0]    top_tok;
  logic [LANES-1:0] top_mask, lvl_mask;
  logic [AW-1:0]    lvl_addr;
  assign top_tok  = top_ent[EW-1 -: TW];
  assign top_mask = top_ent[LANES-1:0];
  assign lvl_addr = lvl_ent[LANES +: AW];
  assign lvl_mask = lvl_ent[LANES-1:0];

  // branch classification
  logic [LANES-1:0] eff;
  logic             none_take, all_take;

  simd_div_cls #(.LANES(LANES)) u_cls (
    .mask     (active_mask),
    .pred     (ev_pred),
    .eff      (eff),
    .none_take(none_take),
    .all_take (all_take)
  );

  logic stack_full, tok_hit;
  assign stack_full = (stack_depth == DW'(DEPTH));
  assign tok_hit    = (stack_depth != '0) && (top_tok == ev_token);

  // next-state decision
  logic [LANES-1:0] mask_n;
  logic [DW-1:0]    depth_n;
  logic             redir_n, ovf_set, unf_set;
  logic [AW-1:0]    pc_n;
  ev_kind_e         kind;

  assign kind = ev_kind_e'(ev_kind);

  always_comb begin
    mask_n  = active_mask;
    depth_n = stack_depth;
    redir_n = 1'b0;
    pc_n    = redirect_pc;
    ovf_set = 1'b0;
    unf_set = 1'b0;
    wr_en   = 1'b0;
    wr_idx  = IW'(stack_depth);
    wr_ent  = {ev_token, ev_target, active_mask};
    if (ev_valid) begin
      unique case (kind)
        EV_BRANCH: begin
          if (none_take) begin
            redir_n = 1'b1;
            pc_n    = ev_target;
          end else if (!all_take) begin
            if (stack_full) begin
              ovf_set = 1'b1;
            end else begin
              wr_en   = 1'b1;
              mask_n  = eff;
              depth_n = stack_depth + DW'(1);
            end
          end
        end
        EV_ELSE: begin
          if (tok_hit) begin
            mask_n = top_mask & ~active_mask;
          end else begin
            redir_n = 1'b1;
            pc_n    = ev_target;
          end
        end
        EV_ENDIF: begin
          if (tok_hit) begin
            mask_n  = top_mask;
            depth_n = stack_depth - DW'(1);
          end
        end
        EV_UNWIND: begin
          if (ev_level < stack_depth) begin
            depth_n = ev_level;
            mask_n  = lvl_mask;
            redir_n = 1'b1;
            pc_n    = lvl_addr;
          end else begin
            unf_set = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_mask   <= '1;
      stack_depth   <= '0;
      redirect      <= 1'b0;
      redirect_pc   <= '0;
      overflow_err  <= 1'b0;
      underflow_err <= 1'b0;
    end else begin
      active_mask   <= mask_n;
      stack_depth   <= depth_n;
      redirect      <= redir_n;
      redirect_pc   <= pc_n;
      overflow_err  <= overflow_err | ovf_set;
      underflow_err <= underflow_err | unf_set;
    end
  end

  // R11
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    overflow_err |=> overflow_err);

  // R12
  unf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    underflow_err |=> underflow_err);

  // R11
  depth_bound_chk: assert property (@(posedge clk) disable iff (rst)
    stack_depth <= DW'(DEPTH));

  // R13
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ev_valid |=> ($stable(active_mask) && $stable(stack_depth) && !redirect));

  // R2
  push_narrows_chk: assert property (@(posedge clk) disable iff (rst)
    (stack_depth == $past(stack_depth) + DW'(1)) |->
      ((active_mask & ~$past(active_mask)) == '0));

  // R8
  pop_widens_chk: assert property (@(posedge clk) disable iff (rst)
    (stack_depth < $past(stack_depth)) |->
      (($past(active_mask) & ~active_mask) == '0));
endmodule

// File: tb/simd_div_stack_tb.sv
`timescale 1ns/1ps
module simd_div_stack_tb;
  localparam int L  = 8;
  localparam int D  = 4;
  localparam int A  = 8;
  localparam int T  = 3;
  localparam int DW = $clog2(D + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ev_valid = 1'b0;
  logic [1:0]    ev_kind = '0;
  logic [L-1:0]  ev_pred = '0;
  logic [A-1:0]  ev_target = '0;
  logic [T-1:0]  ev_token = '0;
  logic [DW-1:0] ev_level = '0;
  logic [L-1:0]  active_mask;
  logic          redirect;
  logic [A-1:0]  redirect_pc;
  logic [DW-1:0] stack_depth;
  logic          overflow_err, underflow_err;

  always #2.5 clk = ~clk;

  simd_div_stack #(.LANES(L), .DEPTH(D), .AW(A), .TW(T)) u_dut (
    .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_kind(ev_kind),
    .ev_pred(ev_pred), .ev_target(ev_target), .ev_token(ev_token),
    .ev_level(ev_level), .active_mask(active_mask), .redirect(redirect),
    .redirect_pc(redirect_pc), .stack_depth(stack_depth),
    .overflow_err(overflow_err), .underflow_err(underflow_err)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference state
  logic [L-1:0] m_mask;
  int           m_depth;
  logic [T-1:0] m_tok [D];
  logic [A-1:0] m_addr [D];
  logic [L-1:0] m_sav [D];
  logic         m_ovf, m_unf;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic chk_all(input string tag, input logic er, input logic [A-1:0] epc);
    chk(tag, "mask", int'(active_mask), int'(m_mask));
    chk(tag, "depth", int'(stack_depth), m_depth);
    chk(tag, "redirect", int'(redirect), int'(er));
    if (er) chk(tag, "redirect_pc", int'(redirect_pc), int'(epc));
    chk(tag, "overflow", int'(overflow_err), int'(m_ovf));
    chk(tag, "underflow", int'(underflow_err), int'(m_unf));
  endtask

  task automatic model_reset();
    m_mask = '1; m_depth = 0; m_ovf = 0; m_unf = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; ev_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_reset();
    chk_all("R1", 1'b0, '0);
  endtask

  task automatic do_ev(input logic [1:0] k, input logic [L-1:0] p,
                       input logic [A-1:0] tgt, input logic [T-1:0] tok,
                       input int lvl);
    string tag;
    logic er;
    logic [A-1:0] epc;
    logic [L-1:0] eff;
    er = 1'b0; epc = '0; tag = "R13";
    case (k)
      2'd0: begin
        eff = p & m_mask;
        if (eff == '0) begin tag = "R3"; er = 1'b1; epc = tgt; end
        else if (eff == m_mask) tag = "R4";
        else if (m_depth == D) begin tag = "R11"; m_ovf = 1'b1; end
        else begin
          tag = "R2";
          m_tok[m_depth] = tok; m_addr[m_depth] = tgt; m_sav[m_depth] = m_mask;
          m_depth++; m_mask = eff;
        end
      end
      2'd1: begin
        if (m_depth != 0 && m_tok[m_depth-1] == tok) begin
          tag = "R6"; m_mask = m_sav[m_depth-1] & ~m_mask;
        end else begin tag = "R7"; er = 1'b1; epc = tgt; end
      end
      2'd2: begin
        tag = "R8";
        if (m_depth != 0 && m_tok[m_depth-1] == tok) begin
          m_depth--; m_mask = m_sav[m_depth];
        end
      end
      default: begin
        if (lvl < m_depth) begin
          tag = "R10"; m_depth = lvl; m_mask = m_sav[lvl];
          er = 1'b1; epc = m_addr[lvl];
        end else begin tag = "R12"; m_unf = 1'b1; end
      end
    endcase
    @(negedge clk);
    ev_valid = 1'b1; ev_kind = k; ev_pred = p; ev_target = tgt;
    ev_token = tok; ev_level = DW'(lvl);
    @(negedge clk);
    ev_valid = 1'b0;
    chk_all(tag, er, epc);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();

    // Sweep 1: every predicate from the full mask (R2, R3, R4, R6, R7, R8)
    for (int p = 0; p < 256; p++) begin
      do_ev(2'd0, L'(p), A'(p), 3'd1, 0);
      do_ev(2'd1, '0, A'(8'hE0), 3'd1, 0);
      do_ev(2'd2, '0, '0, 3'd1, 0);
    end

    // Sweep 2: partial mask 0x0F, inactive lanes carry any predicate (R5)
    do_ev(2'd0, 8'h0F, 8'h11, 3'd2, 0);
    for (int p = 0; p < 256; p++) begin
      do_ev(2'd0, L'(p), A'(p), 3'd3, 0);
      if (((p & 8'h0F) != 0) && ((p & 8'h0F) != 8'h0F))
        chk("R5", "mask ignores idle lanes", int'(active_mask), p & 8'h0F);
      else
        chk("R5", "mask kept on unanimous", int'(active_mask), 8'h0F);
      do_ev(2'd2, '0, '0, 3'd3, 0);
    end
    do_ev(2'd2, '0, '0, 3'd2, 0);

    // R9: LIFO nesting; outer ENDIF cannot pop the inner entry
    do_ev(2'd0, 8'hF0, 8'h20, 3'd1, 0);
    do_ev(2'd0, 8'h30, 8'h21, 3'd2, 0);
    do_ev(2'd2, '0, '0, 3'd1, 0);
    chk("R9", "outer ENDIF ignored", int'(active_mask), 8'h30);
    do_ev(2'd1, '0, 8'h22, 3'd2, 0);
    chk("R9", "inner ELSE mask", int'(active_mask), 8'hC0);
    do_ev(2'd2, '0, '0, 3'd2, 0);
    do_ev(2'd2, '0, '0, 3'd1, 0);
    chk("R9", "outer restore", int'(active_mask), 8'hFF);

    // R13: idle cycles change nothing, redirect drops
    do_ev(2'd0, 8'h00, 8'h55, 3'd1, 0);
    repeat (3) begin
      @(negedge clk);
      chk_all("R13", 1'b0, '0);
    end

    // Fill the stack with distinct masks, then overflow (R11)
    do_ev(2'd0, 8'h7F, 8'h40, 3'd1, 0);
    do_ev(2'd0, 8'h3F, 8'h41, 3'd2, 0);
    do_ev(2'd0, 8'h1F, 8'h42, 3'd3, 0);
    do_ev(2'd0, 8'h0F, 8'h43, 3'd4, 0);
    do_ev(2'd0, 8'h07, 8'h44, 3'd5, 0);
    chk("R11", "overflow raised", int'(overflow_err), 1);
    do_ev(2'd0, 8'hFF, 8'h45, 3'd5, 0);
    // R10: unwind into the middle
    do_ev(2'd3, '0, '0, 3'd0, 1);
    chk("R10", "unwind mask", int'(active_mask), 8'h7F);
    // R12: unwind out of range
    do_ev(2'd3, '0, '0, 3'd0, 3);
    do_ev(2'd3, '0, '0, 3'd0, 1);
    do_ev(2'd3, '0, '0, 3'd0, 0);
    do_ev(2'd3, '0, '0, 3'd0, 0);
    chk("R12", "underflow raised", int'(underflow_err), 1);
    // R7: ELSE on empty stack
    do_ev(2'd1, '0, 8'h99, 3'd1, 0);

    // R1: reset clears sticky errors
    do_reset();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule